// File: doc/BRIEF.md
# Capture Input Pulse-Width Filter

This block cleans up the pin inputs of four input-capture channels before they reach the capture logic. Each pin is first brought into the bus-clock domain through a two-flop synchronizer. After that, a per-channel delay counter measures how long the synchronized input has differed from the level the filter last accepted. A new level is accepted only once it has been held for the programmed number of bus cycles. The accepted level is presented on a filtered-level output. On the cycle of acceptance, a one-cycle valid-edge strobe tells the capture logic to record the timer.

One delay-count setting is shared by all channels, but each channel runs its own counter independently. The setting can be as large as 256 cycles. If the input falls back to the accepted level before the count completes, the counter is cleared, so a train of short glitches can never add up to an accepted edge. A setting of zero turns the filter into a plain synchronizer, which then behaves like a one-cycle filter. The synchronizer delay is not counted as part of the measured pulse. Because the pin is asynchronous, a pulse whose length falls between one count below the threshold and the threshold itself may go either way, depending on where it lands relative to the sample points.

Top module: `pwf_filter`

## Requirements
- R1: Each of the four channels filters its own pin with its own counter; activity on one channel never produces a strobe or level change on another.
- R2: While reset is asserted and right after it is released, every filtered level is 0 and every strobe is 0.
- R3: Let D be the larger of the delay setting and 1. A pin pulse held for D-1 or fewer bus cycles is rejected: it gives no strobe and leaves the filtered level unchanged.
- R4: A pin level held for D or more bus cycles is accepted: the filtered level takes the new value, and the strobe fires.
- R5: The strobe is high for exactly one bus cycle per accepted edge, and the filtered level changes in that same cycle and at no other time.
- R6: For a pin change held long enough, the strobe and the new filtered level appear D+2 clock edges after the first edge that samples the new pin level (2 synchronizer edges plus D counting edges).
- R7: When the synchronized input returns to the accepted level, the count restarts from zero; two sub-threshold pulses separated by one cycle are both rejected.
- R8: The filter supports a delay setting of 256: a 255-cycle pulse is rejected and a 256-cycle pulse is accepted.
- R9: A delay setting of 0 bypasses the filter: a one-cycle pin pulse produces a rising and then a falling accepted edge.
- R10: With the delay setting held constant, two successive strobes on the same channel are at least D cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_CH (4) | Asynchronous capture pin inputs, one bit per channel |
| dly_cnt | input | CNT_W (9) | Shared delay-count setting in bus cycles; 0 selects bypass |
| filt_lvl | output | NUM_CH (4) | Filtered (accepted) level per channel |
| edge_stb | output | NUM_CH (4) | One-cycle valid-edge strobe per channel |

## Verification
A counter that is off by one shows up at the ports within a single pulse. A pulse of exactly D-1 or D cycles then lands on the wrong side of the threshold, and the strobe shows up one edge earlier or later than D+2. A counter that fails to clear on a return to the accepted level makes two short pulses in a row produce a strobe. A channel that shares state with another shows a strobe while only the other channel's pin moves. The stimulus places pulse lengths right at the threshold, including the 256-cycle boundary and the zero-setting bypass, so each of these faults appears within one trial of a few hundred cycles.

// File: rtl/pwf_pkg.sv
package pwf_pkg;
   localparam int DEF_NUM_CH   = 4;
   localparam int DEF_MAX_DLY  = 256;
   localparam int SYNC_MIN     = 2;

   // Bits needed to hold a count from 0 up to max_val inclusive.
   function automatic int cnt_bits(input int max_val);
      int w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction
endpackage

// File: rtl/pwf_sync.sv
module pwf_sync #(
   parameter int STAGES = pwf_pkg::SYNC_MIN
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < pwf_pkg::SYNC_MIN) begin : g_bad_stages
         $error("pwf_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pwf_chan.sv
module pwf_chan #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_sync,
   input  logic [CNT_W-1:0] dly,
   output logic             lvl,
   output logic             stb
);
   logic [CNT_W-1:0] cnt_q;
   logic             lvl_q;
   logic             stb_q;
   logic             differs;
   logic [CNT_W:0]   cnt_inc;
   logic             done;

   assign differs = (in_sync != lvl_q);
   assign cnt_inc = {1'b0, cnt_q} + 1'b1;
   assign done    = (cnt_inc >= {1'b0, dly});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
         stb_q <= 1'b0;
      end else if (!differs) begin
         cnt_q <= '0;
         stb_q <= 1'b0;
      end else if (done) begin
         cnt_q <= '0;
         lvl_q <= in_sync;
         stb_q <= 1'b1;
      end else begin
         cnt_q <= cnt_inc[CNT_W-1:0];
         stb_q <= 1'b0;
      end
   end

   assign lvl = lvl_q;
   assign stb = stb_q;
endmodule

// File: rtl/pwf_filter.sv
module pwf_filter #(
   parameter int NUM_CH      = pwf_pkg::DEF_NUM_CH,
   parameter int MAX_DLY     = pwf_pkg::DEF_MAX_DLY,
   parameter int SYNC_STAGES = pwf_pkg::SYNC_MIN,
   parameter int CNT_W       = pwf_pkg::cnt_bits(MAX_DLY)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pin_in,
   input  logic [CNT_W-1:0]  dly_cnt,
   output logic [NUM_CH-1:0] filt_lvl,
   output logic [NUM_CH-1:0] edge_stb
);
   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("pwf_filter: NUM_CH must be at least 1");
      end
      if ((1 << CNT_W) <= MAX_DLY) begin : g_bad_w
         $error("pwf_filter: CNT_W too narrow for MAX_DLY");
      end
   endgenerate

   logic [NUM_CH-1:0] pin_sync;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         pwf_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (pin_in[ch]),
            .q_sync  (pin_sync[ch])
         );
         pwf_chan #(.CNT_W(CNT_W)) i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_sync (pin_sync[ch]),
            .dly     (dly_cnt),
            .lvl     (filt_lvl[ch]),
            .stb     (edge_stb[ch])
         );
      end
   endgenerate
endmodule

// File: rtl/pwf_filter_chk.sv
module pwf_filter_chk #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  dly_cnt,
   input logic [NUM_CH-1:0] filt_lvl,
   input logic [NUM_CH-1:0] edge_stb
);
   localparam int GAP_W = CNT_W + 1;

   logic [CNT_W-1:0] dly_q;

   always_ff @(posedge clk) begin
      if (!rst_n) dly_q <= '0;
      else        dly_q <= dly_cnt;
   end

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
         logic [GAP_W-1:0] gap_q;
         logic             seen_q;
         logic             moved_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               gap_q   <= '0;
               seen_q  <= 1'b0;
               moved_q <= 1'b0;
            end else if (edge_stb[i]) begin
               gap_q   <= '0;
               seen_q  <= 1'b1;
               moved_q <= 1'b0;
            end else begin
               if (gap_q != {GAP_W{1'b1}}) gap_q <= gap_q + 1'b1;
               if (dly_cnt != dly_q) moved_q <= 1'b1;
            end
         end

         a_r5_one_cycle_stb: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_stb[i] && dly_cnt > 1) |=> (!edge_stb[i] || !$stable(dly_cnt)));

         a_r5_lvl_moves_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
            !edge_stb[i] |-> $stable(filt_lvl[i]));

         a_r4_stb_toggles: assert property (@(posedge clk) disable iff (!rst_n)
            edge_stb[i] |-> (filt_lvl[i] != $past(filt_lvl[i])));

         a_r10_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_stb[i] && seen_q && !moved_q && dly_cnt == dly_q)
               |-> ({1'b0, gap_q} + 1'b1 >= {2'b0, dly_cnt}));
      end
   endgenerate
endmodule

bind pwf_filter pwf_filter_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dly_cnt  (dly_cnt),
   .filt_lvl (filt_lvl),
   .edge_stb (edge_stb)
);

// File: tb/test_pwf_filter.sv
`timescale 1ns/1ps
module test_pwf_filter;
   localparam int NCH = 4;
   localparam int CW  = 9;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] pin_in = '0;
   logic [CW-1:0]  dly_cnt = '0;
   logic [NCH-1:0] filt_lvl;
   logic [NCH-1:0] edge_stb;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;
   int scnt [NCH];
   int first [NCH];
   bit flvl [NCH];
   int start [NCH];

   pwf_filter i_pwf_filter (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dly_cnt(dly_cnt),
      .filt_lvl(filt_lvl), .edge_stb(edge_stb)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc = cyc + 1;

   always @(negedge clk) begin
      for (int i = 0; i < NCH; i++) begin
         if (edge_stb[i]) begin
            if (scnt[i] == 0) begin
               first[i] = cyc;
               flvl[i]  = filt_lvl[i];
            end
            scnt[i] = scnt[i] + 1;
         end
      end
   end

   function automatic int eff_dly(input int d);
      return (d < 1) ? 1 : d;
   endfunction

   function automatic int exp_strobes(input int d, input int n);
      return (n >= eff_dly(d)) ? 2 : 0;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic clear_mon();
      @(posedge clk);
      #1;
      for (int i = 0; i < NCH; i++) begin
         scnt[i] = 0; first[i] = 0; flvl[i] = 0;
      end
   endtask

   task automatic set_dly(input int d);
      @(negedge clk);
      dly_cnt = CW'(d);
      repeat (3) @(negedge clk);
   endtask

   task automatic run_pulse(input int ch, input int n);
      @(negedge clk);
      pin_in[ch] = 1'b1;
      start[ch] = cyc;
      repeat (n) @(negedge clk);
      pin_in[ch] = 1'b0;
   endtask

   task automatic settle(input int d);
      repeat (eff_dly(d) + 8) @(negedge clk);
   endtask

   // Single-channel trial: strobe count, latency, level, idle channels quiet.
   task automatic trial(input int ch, input int d, input int n, input string tag);
      int e;
      set_dly(d);
      clear_mon();
      run_pulse(ch, n);
      settle(d);
      e = exp_strobes(d, n);
      chk(scnt[ch] == e, (e == 2) ? {tag, " R4 accept"} : {tag, " R3 reject"}, scnt[ch], e);
      if (e == 2) begin
         chk(first[ch] - start[ch] == eff_dly(d) + 2, {tag, " R6 latency"},
             first[ch] - start[ch], eff_dly(d) + 2);
         chk(flvl[ch] == 1'b1, {tag, " R5 level with strobe"}, flvl[ch], 1);
      end
      for (int k = 0; k < NCH; k++)
         if (k != ch) chk(scnt[k] == 0, {tag, " R1 other channel quiet"}, scnt[k], 0);
      chk(filt_lvl == '0, {tag, " R4 level back to 0"}, filt_lvl, 0);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int d, n, ch;
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < NCH; i++) begin scnt[i] = 0; first[i] = 0; flvl[i] = 0; start[i] = 0; end

      repeat (4) @(negedge clk);
      chk(filt_lvl == '0 && edge_stb == '0, "R2 during reset", {filt_lvl, edge_stb}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(filt_lvl == '0 && edge_stb == '0, "R2 after reset", {filt_lvl, edge_stb}, 0);

      // Threshold corners
      trial(0, 5, 4, "D5 N4");
      trial(1, 5, 5, "D5 N5");
      trial(2, 1, 1, "D1 N1");
      trial(3, 2, 1, "D2 N1");

      // R9 bypass: a single-cycle pulse passes both edges
      trial(0, 0, 1, "R9 bypass");

      // R8: largest delay setting
      trial(1, 256, 255, "R8 D256 N255");
      trial(2, 256, 256, "R8 D256 N256");

      // R7: restart on return to accepted level
      set_dly(10);
      clear_mon();
      run_pulse(3, 8);
      @(negedge clk);
      run_pulse(3, 8);
      settle(10);
      chk(scnt[3] == 0, "R7 two short pulses rejected", scnt[3], 0);
      clear_mon();
      run_pulse(3, 9);
      @(negedge clk);
      run_pulse(3, 10);
      settle(10);
      chk(scnt[3] == 2, "R7 second pulse alone accepted", scnt[3], 2);

      // R1: concurrent channels with different pulse lengths
      set_dly(12);
      clear_mon();
      fork
         run_pulse(0, 20);
         run_pulse(1, 5);
         run_pulse(2, 12);
         run_pulse(3, 11);
      join
      settle(12);
      chk(scnt[0] == 2, "R1 ch0 long", scnt[0], 2);
      chk(scnt[1] == 0, "R1 ch1 short", scnt[1], 0);
      chk(scnt[2] == 2, "R1 ch2 at threshold", scnt[2], 2);
      chk(scnt[3] == 0, "R1 ch3 one below", scnt[3], 0);

      // Constrained random trials, lengths biased around the threshold
      for (int t = 0; t < 60; t++) begin
         d  = $urandom_range(0, 40);
         ch = $urandom_range(0, NCH - 1);
         n  = eff_dly(d) + $urandom_range(0, 6) - 3;
         if (n < 1) n = 1;
         if ($urandom_range(0, 3) == 0) n = $urandom_range(1, 50);
         trial(ch, d, n, "random");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule